// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Switchover

This block watches a primary device clock against an internal reference clock that is always running. A divider turns the reference into a slow sample window of `DIV` reference cycles. The window opens at its midpoint and is judged at its end. Each falling edge of the device clock flips a toggle flop in the device domain. That toggle is synchronized into the reference domain, and any change seen while the window is open marks the device clock as alive.

When a window closes with no change seen, and monitoring is enabled, the block declares a clock failure. It latches a failure status. It drives the clock-select output to the internal source. It raises a sticky interrupt flag that software clears. It gives the external watchdog and its postscaler a single one-cycle reset pulse, so their timing restarts at the moment the clock speed changes. The clock-source status that software reads is kept outside this block and is not touched by a failure, so that status and the clock select disagree after an event; that mismatch is how the fail-safe state shows.

The failure state holds until reset, even if the device clock comes back. A fault of the reference clock itself cannot be seen by this block.

Top module: `clk_fail_monitor`

## Requirements
- R1: After rst_ni is asserted, fail_o, irq_flag_o, clk_sel_o and wdt_rst_o are all 0.
- R2: With monitoring enabled and the device clock running faster than the reference, fail_o stays 0.
- R3: When the device clock stops while mon_en_i is 1, fail_o rises within DIV + DIV/2 + 8 reference cycles. A failure is decided only at the end of a sample window.
- R4: On a failure, irq_flag_o is set in the same cycle as fail_o. It then stays 1 until it is cleared.
- R5: On a failure, clk_sel_o goes to 1, which selects the internal source. A value of 0 selects the device clock.
- R6: Each failure produces exactly one wdt_rst_o pulse, one reference cycle wide, in the cycle where fail_o rises.
- R7: While mon_en_i is 0, no failure is declared, even if the device clock is stopped.
- R8: fail_o and clk_sel_o stay 1 until reset. A returning device clock does not clear them, and it produces no further wdt_rst_o pulses.
- R9: irq_clr_i at 1 clears irq_flag_o one cycle later and leaves fail_o and clk_sel_o unchanged. If a failure and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Always-running internal reference clock |
| dev_clk_i | input | 1 | Primary device clock under watch |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_en_i | input | 1 | Monitoring enable setting |
| irq_clr_i | input | 1 | Clear for the sticky interrupt flag |
| fail_o | output | 1 | Latched clock-failure status |
| irq_flag_o | output | 1 | Sticky oscillator-fail interrupt flag |
| clk_sel_o | output | 1 | Clock select: 1 selects the internal source |
| wdt_rst_o | output | 1 | One-cycle reset pulse for the watchdog and its postscaler |

## Verification
The bench runs a fast device clock for many windows. A monitor that aliased the toggle, or judged a window before arming it, would raise a false failure there. It then stops the clock with monitoring disabled, where a block that ignores the enable would fail at once. With monitoring enabled it stops the clock again and counts the cycles until fail_o rises; a block that judges on the wrong edge, or never clears its seen flag, would take too long or never fire. A scoreboard matches each watchdog pulse against an expected event, so a pulse repeated on every window or after the clock returns is reported as an extra. It also checks that the clear of the interrupt flag leaves the latched failure in place.

// File: rtl/clk_fail_monitor_pkg.sv
package clk_fail_monitor_pkg;
  localparam int unsigned DIV_DEFAULT  = 64;
  localparam int unsigned SYNC_DEFAULT = 2;

  typedef struct packed {
    logic open_stb;   // window armed (sample rising point)
    logic judge_stb;  // window judged (sample falling point)
  } win_stb_t;
endpackage

// File: rtl/cfm_window_gen.sv
module cfm_window_gen
  import clk_fail_monitor_pkg::*;
#(
  parameter int unsigned DIV = DIV_DEFAULT
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output win_stb_t stb_o
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    stb_o.open_stb  = (cnt_q == CW'(HALF - 1));
    stb_o.judge_stb = (cnt_q == CW'(DIV - 1));
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stb_o.open_stb && stb_o.judge_stb));
endmodule

// File: rtl/cfm_edge_tracker.sv
module cfm_edge_tracker
  import clk_fail_monitor_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEFAULT
) (
  input  logic dev_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic chg_o
);
  logic              tog_q;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(negedge dev_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else tog_q <= ~tog_q;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge ref_clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else sync_q[0] <= tog_q;
      end
    end else begin : g_chain
      always_ff @(posedge ref_clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign chg_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cfm_detector.sv
module cfm_detector
  import clk_fail_monitor_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     clr_i,
  input  win_stb_t stb_i,
  input  logic     chg_i,
  output logic     fail_o,
  output logic     irq_o,
  output logic     sel_o,
  output logic     wdt_o
);
  logic armed_q, seen_q, fail_q, sel_q, irq_q, wdt_q;
  logic evt;

  assign evt = en_i & armed_q & stb_i.judge_stb & ~seen_q & ~chg_i & ~fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (stb_i.open_stb) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else if (stb_i.judge_stb) begin
      armed_q <= 1'b0;
    end else if (chg_i) begin
      seen_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      sel_q  <= 1'b0;
      wdt_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (evt) fail_q <= 1'b1;
      if (evt) sel_q  <= 1'b1;
      wdt_q <= evt;
      if (evt) irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign fail_o = fail_q;
  assign sel_o  = sel_q;
  assign irq_o  = irq_q;
  assign wdt_o  = wdt_q;

  // R6
  wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_q |=> !wdt_q);
  // R8
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> (fail_q && sel_q));
  // R4
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> wdt_q);
  // R7
  no_fail_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(fail_q));
  // R3
  fail_on_judge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(stb_i.judge_stb));
  // R5
  sel_with_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> (sel_q && irq_q));
endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor
  import clk_fail_monitor_pkg::*;
#(
  parameter int unsigned DIV         = DIV_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic ref_clk_i,
  input  logic dev_clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic irq_clr_i,
  output logic fail_o,
  output logic irq_flag_o,
  output logic clk_sel_o,
  output logic wdt_rst_o
);
  win_stb_t stb;
  logic     chg;

  cfm_window_gen #(.DIV(DIV)) u_win (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  cfm_edge_tracker #(.STAGES(SYNC_STAGES)) u_trk (
    .dev_clk_i(dev_clk_i),
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .chg_o    (chg)
  );

  cfm_detector u_det (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .en_i  (mon_en_i),
    .clr_i (irq_clr_i),
    .stb_i (stb),
    .chg_i (chg),
    .fail_o(fail_o),
    .irq_o (irq_flag_o),
    .sel_o (clk_sel_o),
    .wdt_o (wdt_rst_o)
  );
endmodule

// File: tb/clk_fail_monitor_test.sv
module clk_fail_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 64;
  localparam int BOUND      = DIV + DIV / 2 + 8;

  logic ref_clk = 1'b0;
  logic dev_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic mon_en  = 1'b0;
  logic irq_clr = 1'b0;
  logic dev_run = 1'b1;
  logic fail, irq, sel, wdt;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  clk_fail_monitor #(.DIV(DIV)) uut (
    .ref_clk_i (ref_clk),
    .dev_clk_i (dev_clk),
    .rst_ni    (rst_n),
    .mon_en_i  (mon_en),
    .irq_clr_i (irq_clr),
    .fail_o    (fail),
    .irq_flag_o(irq),
    .clk_sel_o (sel),
    .wdt_rst_o (wdt)
  );

  always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;
  initial forever begin
    #2;
    if (dev_run) dev_clk = ~dev_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // driver side: announce an expected watchdog pulse
  task automatic expect_event(input int id);
    exp_q.push_back(id);
  endtask

  // monitor: each pulse must match one expected event
  always @(negedge ref_clk) begin
    if (rst_n && wdt) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 extra pulse", 1, 0);
      end else begin
        void'(exp_q.pop_front());
        chk(fail == 1'b1, "R6 pulse with fail", int'(fail), 1);
        chk(irq == 1'b1, "R4 irq with fail", int'(irq), 1);
        chk(sel == 1'b1, "R5 sel internal", int'(sel), 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    cyc(3);
    // R1 reset state
    chk({fail, irq, sel, wdt} == 4'b0, "R1 reset", int'({fail, irq, sel, wdt}), 0);
    rst_n = 1'b1;
    cyc(2);
    chk({fail, irq, sel, wdt} == 4'b0, "R1 after release", int'({fail, irq, sel, wdt}), 0);

    // R2 running clock, enabled
    mon_en = 1'b1;
    cyc(DIV * 10);
    chk(fail == 1'b0, "R2 no false fail", int'(fail), 0);
    chk(sel == 1'b0, "R2 sel device", int'(sel), 0);

    // R7 stopped clock while disabled
    mon_en = 1'b0;
    dev_run = 1'b0;
    cyc(DIV * 4);
    chk(fail == 1'b0, "R7 disabled no fail", int'(fail), 0);
    chk(irq == 1'b0, "R7 disabled no irq", int'(irq), 0);
    dev_run = 1'b1;
    cyc(8);
    mon_en = 1'b1;
    cyc(DIV * 3);
    chk(fail == 1'b0, "R2 after reenable", int'(fail), 0);

    // R3 stop while enabled
    expect_event(1);
    dev_run = 1'b0;
    lat = 0;
    while (!fail && lat < 4 * DIV) begin
      cyc(1);
      lat++;
    end
    chk(fail == 1'b1, "R3 detected", int'(fail), 1);
    chk(lat <= BOUND, "R3 latency", lat, BOUND);
    cyc(1);
    chk(wdt == 1'b0, "R6 pulse one cycle", int'(wdt), 0);
    chk(exp_q.size() == 0, "R6 pulse seen", exp_q.size(), 0);

    // R8 clock returns, state held
    dev_run = 1'b1;
    cyc(DIV * 5);
    chk(fail == 1'b1, "R8 fail held", int'(fail), 1);
    chk(sel == 1'b1, "R8 sel held", int'(sel), 1);
    chk(irq == 1'b1, "R4 irq sticky", int'(irq), 1);

    // R9 clear
    irq_clr = 1'b1;
    cyc(1);
    irq_clr = 1'b0;
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    chk(fail == 1'b1, "R9 fail kept", int'(fail), 1);
    chk(sel == 1'b1, "R9 sel kept", int'(sel), 1);
    cyc(DIV * 2);
    chk(irq == 1'b0, "R9 stays clear", int'(irq), 0);

    // R1 reset again
    rst_n = 1'b0;
    cyc(2);
    chk({fail, irq, sel, wdt} == 4'b0, "R1 second reset", int'({fail, irq, sel, wdt}), 0);
    rst_n = 1'b1;
    cyc(DIV * 3);
    chk(fail == 1'b0, "R2 after second reset", int'(fail), 0);
    chk(exp_q.size() == 0, "R6 queue empty", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule